// File: doc/BRIEF.md
# Programmed-IO Command Sequencer

This block runs one software-initiated transfer on a byte-oriented bus master. Software sets up the transfer through a small register port: a byte count, a target address and an opcode. For a write it also fills a bank of 32-bit data words. It then sets the go bit. The sequencer presents the opcode, address and count to the bus master with a one-cycle start pulse, then moves the bytes.

On a write, the bytes are taken from the data bank. On a read, each byte returned by the bus master is stored back into the same bank. Bytes are packed little-endian, byte 0 in the low lane of word 0.

When the last byte has moved, the go bit clears and a sticky completion bit is set. The interrupt output is high while that bit is set and interrupts are enabled. A count larger than the bank can hold is refused: no transfer takes place and an error bit is set.

The register port uses a valid/ready handshake. It is always ready, and read data is returned combinationally in the cycle the read is accepted. The bus master side has a valid/ready byte stream in each direction.

Top module: `pio_sequencer`

## Requirements
- R1: After reset, the control register, the status register and `irq` all read 0.
- R2: Register word addresses are: control at 0 (bit 0 go, bit 1 interrupt enable), status at 1 (bit 0 done, bit 1 error), count at 2 (8 bits), target address at 3, opcode at 4 (8 bits), and data word k at 32+k for k = 0..15. While idle, each of these reads back the value last written. Unmapped addresses read 0.
- R3: Writing 1 to go while idle, with count ≤ 64, raises `bm_start` for exactly one cycle. During that cycle `bm_opcode`, `bm_addr` and `bm_count` carry the programmed values. Go reads 1 until the transfer ends.
- R4: Opcode bit 0 = 0 selects a write. Byte i (i = 0..count-1) is `[8*(i%4)+7 : 8*(i%4)]` of data word i/4, and the bytes are sent in order on `bm_wvalid`/`bm_wready` handshakes.
- R5: Opcode bit 0 = 1 selects a read. The i-th byte accepted on `bm_rvalid`/`bm_rready` is stored at the same byte position of the bank. Bank bytes at or beyond the count keep their values.
- R6: When count bytes have moved, go clears and status done is set. A count of 0 completes with no byte handshake.
- R7: A go with count > 64 starts nothing: `bm_start` stays low, go reads 0, and status error and done are both set.
- R8: While busy, writes to count, address, opcode, data words and the go bit are ignored.
- R9: Status bits are write-1-to-clear. Writing 0 to a bit leaves it unchanged.
- R10: `irq` equals status done AND interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access request |
| reg_ready | output | 1 | Register access accepted (always 1) |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | REG_AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the accepting cycle |
| irq | output | 1 | Completion interrupt |
| bm_start | output | 1 | One-cycle transfer start |
| bm_opcode | output | 8 | Transfer opcode |
| bm_addr | output | ADDR_W | Transfer target address |
| bm_count | output | COUNT_W | Transfer byte count |
| bm_wvalid | output | 1 | Write byte valid |
| bm_wready | input | 1 | Write byte accepted |
| bm_wdata | output | 8 | Write byte |
| bm_rvalid | input | 1 | Read byte valid |
| bm_rready | output | 1 | Read byte accepted |
| bm_rdata | input | 8 | Read byte |

## Verification
Some properties are checked on every cycle by the assertions:
- the byte index never passes the latched count;
- the start pulse lasts one cycle and only while busy;
- the write and read streams are never offered together;
- a refused go leaves the block idle;
- done is set in the same cycle that busy falls;
- the configuration registers stay stable while busy;
- a captured read byte never collides with a register write to the bank.

Other properties can only be shown by the bench scenarios:
- the byte order and little-endian packing of both streams;
- that bank bytes beyond the count are preserved;
- that writes made while busy are dropped;
- the write-1-to-clear behaviour;
- the interrupt gating;
- the handling of the count boundary at 64 and 65.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_MOVE = 1'b1
   } seq_state_e;

   // register word indices
   localparam int unsigned RG_CTRL   = 0;
   localparam int unsigned RG_STATUS = 1;
   localparam int unsigned RG_COUNT  = 2;
   localparam int unsigned RG_ADDR   = 3;
   localparam int unsigned RG_OPCODE = 4;

   // bit positions
   localparam int unsigned CTRL_GO_BIT  = 0;
   localparam int unsigned CTRL_IE_BIT  = 1;
   localparam int unsigned STAT_DONE_BIT = 0;
   localparam int unsigned STAT_ERR_BIT  = 1;
   localparam int unsigned OP_READ_BIT   = 0;

endpackage

// File: rtl/pio_seq_databank.sv
module pio_seq_databank #(
   parameter int unsigned WORDS  = 16,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = $clog2(WORDS),
   parameter int unsigned BIDX_W = $clog2(WORDS * (DATA_W / 8))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              bw_en,
   input  logic [BIDX_W-1:0] bw_idx,
   input  logic [7:0]        bw_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   input  logic [BIDX_W-1:0] br_idx,
   output logic [7:0]        br_data
);

   localparam int unsigned LANE_W = $clog2(DATA_W / 8);

   if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("databank: DATA_W must be a multiple of 8 and at least 16");
   end
   if ((1 << IDX_W) != WORDS) begin : g_bad_depth
      $error("databank: WORDS must be a power of two");
   end

   logic [WORDS*DATA_W-1:0] bank_flat;
   logic [LANE_W-1:0]       bw_lane;
   logic [IDX_W-1:0]        bw_word;

   assign bw_lane = bw_idx[LANE_W-1:0];
   assign bw_word = bw_idx[BIDX_W-1:LANE_W];

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (wr_en && wr_idx == IDX_W'(w)) begin
            word_q <= wr_data;
         end else if (bw_en && bw_word == IDX_W'(w)) begin
            word_q[bw_lane*8 +: 8] <= bw_data;
         end
      end
      assign bank_flat[w*DATA_W +: DATA_W] = word_q;
   end

   assign rd_data = bank_flat[rd_idx*DATA_W +: DATA_W];
   assign br_data = bank_flat[br_idx*8 +: 8];

   // R5
   capture_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bw_en |-> !wr_en);

endmodule

// File: rtl/pio_seq_engine.sv
module pio_seq_engine
   import pio_seq_pkg::*;
#(
   parameter int unsigned MAX_BYTES = 64,
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned BIDX_W    = $clog2(MAX_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_req,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic              cfg_read,
   output logic              busy,
   output logic              done_set,
   output logic              err_set,
   output logic [BIDX_W-1:0] byte_idx,
   input  logic [7:0]        wbyte,
   output logic              cap_en,
   output logic [7:0]        cap_data,
   output logic              bm_start,
   output logic              bm_wvalid,
   input  logic              bm_wready,
   output logic [7:0]        bm_wdata,
   input  logic              bm_rvalid,
   output logic              bm_rready,
   input  logic [7:0]        bm_rdata
);

   if (MAX_BYTES >= (1 << CNT_W)) begin : g_bad_cnt
      $error("engine: CNT_W too narrow to flag oversize counts");
   end

   seq_state_e       state_q;
   logic [CNT_W-1:0] idx_q;
   logic [CNT_W-1:0] len_q;
   logic             read_q;
   logic             start_q;
   logic             oversize;
   logic             go_ok;
   logic             go_bad;
   logic             more;
   logic             last;
   logic             fire;

   assign oversize = cfg_count > CNT_W'(MAX_BYTES);
   assign go_ok    = go_req && (state_q == SEQ_IDLE) && !oversize;
   assign go_bad   = go_req && (state_q == SEQ_IDLE) && oversize;
   assign busy     = (state_q == SEQ_MOVE);
   assign last     = busy && (idx_q == len_q);
   assign more     = busy && (idx_q != len_q);

   assign bm_wvalid = more && !read_q;
   assign bm_rready = more && read_q;
   assign bm_wdata  = wbyte;
   assign fire      = (bm_wvalid && bm_wready) || (bm_rready && bm_rvalid);

   assign cap_en   = bm_rready && bm_rvalid;
   assign cap_data = bm_rdata;
   assign byte_idx = idx_q[BIDX_W-1:0];
   assign bm_start = start_q;
   assign done_set = last || go_bad;
   assign err_set  = go_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         idx_q   <= '0;
         len_q   <= '0;
         read_q  <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         unique case (state_q)
            SEQ_IDLE: begin
               if (go_ok) begin
                  state_q <= SEQ_MOVE;
                  idx_q   <= '0;
                  len_q   <= cfg_count;
                  read_q  <= cfg_read;
                  start_q <= 1'b1;
               end
            end
            SEQ_MOVE: begin
               if (last) begin
                  state_q <= SEQ_IDLE;
               end else if (fire) begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   // R4
   idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> idx_q <= len_q);

   // R3
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bm_start |=> !bm_start);

   // R3
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bm_start |-> busy);

   // R4
   stream_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bm_wvalid |-> !bm_rready);

   // R7
   reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_set |=> !busy);

endmodule

// File: rtl/pio_sequencer.sv
module pio_sequencer
   import pio_seq_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned WORDS   = 16,
   parameter int unsigned REG_AW  = 6,
   parameter int unsigned COUNT_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_valid,
   output logic               reg_ready,
   input  logic               reg_write,
   input  logic [REG_AW-1:0]  reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               irq,
   output logic               bm_start,
   output logic [7:0]         bm_opcode,
   output logic [ADDR_W-1:0]  bm_addr,
   output logic [COUNT_W-1:0] bm_count,
   output logic               bm_wvalid,
   input  logic               bm_wready,
   output logic [7:0]         bm_wdata,
   input  logic               bm_rvalid,
   output logic               bm_rready,
   input  logic [7:0]         bm_rdata
);

   localparam int unsigned DATA_W    = 32;
   localparam int unsigned MAX_BYTES = WORDS * (DATA_W / 8);
   localparam int unsigned IDX_W     = $clog2(WORDS);
   localparam int unsigned BIDX_W    = $clog2(MAX_BYTES);

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
      $error("pio_sequencer: ADDR_W must be 1..32");
   end
   if (WORDS > (1 << (REG_AW - 1)) || REG_AW < 4) begin : g_bad_map
      $error("pio_sequencer: data bank does not fit the register space");
   end

   logic                acc_wr;
   logic                busy;
   logic                cfg_wr_ok;
   logic                in_data;
   logic [REG_AW-2:0]   data_off;
   logic                data_hit;
   logic                go_req;
   logic                done_set;
   logic                err_set;
   logic                ie_q;
   logic                done_q;
   logic                err_q;
   logic [COUNT_W-1:0]  count_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [7:0]          opcode_q;
   logic [BIDX_W-1:0]   byte_idx;
   logic [7:0]          wbyte;
   logic                cap_en;
   logic [7:0]          cap_data;
   logic [DATA_W-1:0]   bank_rd;

   assign reg_ready = 1'b1;
   assign acc_wr    = reg_valid && reg_write;
   assign cfg_wr_ok = acc_wr && !busy;
   assign in_data   = reg_addr[REG_AW-1];
   assign data_off  = reg_addr[REG_AW-2:0];
   assign data_hit  = in_data && ({1'b0, data_off} < REG_AW'(WORDS));
   assign go_req    = acc_wr && !in_data && (reg_addr == REG_AW'(RG_CTRL))
                      && reg_wdata[CTRL_GO_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q     <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         count_q  <= '0;
         addr_q   <= '0;
         opcode_q <= '0;
      end else begin
         if (acc_wr && reg_addr == REG_AW'(RG_CTRL)) begin
            ie_q <= reg_wdata[CTRL_IE_BIT];
         end
         if (acc_wr && reg_addr == REG_AW'(RG_STATUS)) begin
            done_q <= (done_q && !reg_wdata[STAT_DONE_BIT]) || done_set;
            err_q  <= (err_q && !reg_wdata[STAT_ERR_BIT]) || err_set;
         end else begin
            done_q <= done_q || done_set;
            err_q  <= err_q || err_set;
         end
         if (cfg_wr_ok && reg_addr == REG_AW'(RG_COUNT)) begin
            count_q <= reg_wdata[COUNT_W-1:0];
         end
         if (cfg_wr_ok && reg_addr == REG_AW'(RG_ADDR)) begin
            addr_q <= reg_wdata[ADDR_W-1:0];
         end
         if (cfg_wr_ok && reg_addr == REG_AW'(RG_OPCODE)) begin
            opcode_q <= reg_wdata[7:0];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (data_hit) begin
         reg_rdata = bank_rd;
      end else if (!in_data) begin
         unique case (reg_addr)
            REG_AW'(RG_CTRL):   reg_rdata = {30'd0, ie_q, busy};
            REG_AW'(RG_STATUS): reg_rdata = {30'd0, err_q, done_q};
            REG_AW'(RG_COUNT):  reg_rdata[COUNT_W-1:0] = count_q;
            REG_AW'(RG_ADDR):   reg_rdata[ADDR_W-1:0] = addr_q;
            REG_AW'(RG_OPCODE): reg_rdata[7:0] = opcode_q;
            default:            reg_rdata = '0;
         endcase
      end
   end

   assign irq       = done_q && ie_q;
   assign bm_opcode = opcode_q;
   assign bm_addr   = addr_q;
   assign bm_count  = count_q;

   pio_seq_databank #(
      .WORDS  (WORDS),
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W),
      .BIDX_W (BIDX_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_ok && data_hit),
      .wr_idx  (data_off[IDX_W-1:0]),
      .wr_data (reg_wdata),
      .bw_en   (cap_en),
      .bw_idx  (byte_idx),
      .bw_data (cap_data),
      .rd_idx  (data_off[IDX_W-1:0]),
      .rd_data (bank_rd),
      .br_idx  (byte_idx),
      .br_data (wbyte)
   );

   pio_seq_engine #(
      .MAX_BYTES (MAX_BYTES),
      .CNT_W     (COUNT_W),
      .BIDX_W    (BIDX_W)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_req    (go_req),
      .cfg_count (count_q),
      .cfg_read  (opcode_q[OP_READ_BIT]),
      .busy      (busy),
      .done_set  (done_set),
      .err_set   (err_set),
      .byte_idx  (byte_idx),
      .wbyte     (wbyte),
      .cap_en    (cap_en),
      .cap_data  (cap_data),
      .bm_start  (bm_start),
      .bm_wvalid (bm_wvalid),
      .bm_wready (bm_wready),
      .bm_wdata  (bm_wdata),
      .bm_rvalid (bm_rvalid),
      .bm_rready (bm_rready),
      .bm_rdata  (bm_rdata)
   );

   // R6
   done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done_q);

   // R8
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(count_q) && $stable(addr_q) && $stable(opcode_q)));

endmodule

// File: tb/pio_sequencer_bench.sv
module pio_sequencer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_valid = 1'b0;
   logic        reg_ready;
   logic        reg_write = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;
   logic        bm_start;
   logic [7:0]  bm_opcode;
   logic [31:0] bm_addr;
   logic [7:0]  bm_count;
   logic        bm_wvalid;
   logic        bm_wready = 1'b0;
   logic [7:0]  bm_wdata;
   logic        bm_rvalid = 1'b0;
   logic        bm_rready;
   logic [7:0]  bm_rdata;

   always #2 clk = ~clk;

   pio_sequencer u_pio_sequencer (
      .clk(clk), .rst_n(rst_n),
      .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_write(reg_write),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq), .bm_start(bm_start), .bm_opcode(bm_opcode), .bm_addr(bm_addr),
      .bm_count(bm_count), .bm_wvalid(bm_wvalid), .bm_wready(bm_wready),
      .bm_wdata(bm_wdata), .bm_rvalid(bm_rvalid), .bm_rready(bm_rready),
      .bm_rdata(bm_rdata)
   );

   int   n_checks = 0;
   int   n_fail = 0;
   bit   finished = 0;
   bit   hold = 0;
   int   wr_cnt = 0;
   int   rd_cnt = 0;
   int   starts = 0;
   logic [7:0]  wr_seen [0:127];
   logic [7:0]  st_op;
   logic [31:0] st_addr;
   logic [7:0]  st_cnt;
   logic [31:0] shadow [0:15];

   function automatic logic [7:0] model_byte(logic [31:0] a, int i);
      logic [7:0] k;
      k = 8'(i);
      return a[7:0] ^ (k * 8'd29 + 8'd17) ^ a[15:8];
   endfunction

   assign bm_rdata = model_byte(bm_addr, rd_cnt);

   // bus master model: random throttling, byte capture
   always @(negedge clk) begin
      bm_wready <= hold ? 1'b0 : ($urandom % 3 != 0);
      bm_rvalid <= hold ? 1'b0 : ($urandom % 3 != 0);
   end

   always @(posedge clk) begin
      if (bm_start) begin
         starts  <= starts + 1;
         st_op   <= bm_opcode;
         st_addr <= bm_addr;
         st_cnt  <= bm_count;
      end
      if (bm_wvalid && bm_wready) begin
         wr_seen[wr_cnt] <= bm_wdata;
         wr_cnt <= wr_cnt + 1;
      end
      if (bm_rvalid && bm_rready) rd_cnt <= rd_cnt + 1;
   end

   task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic reg_wr(logic [5:0] a, logic [31:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0;
   endtask

   task automatic reg_rd(logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_valid = 1'b0;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int t = 0; t < 3000; t++) begin
         reg_rd(6'd0, v);
         if (v[0] == 1'b0) return;
      end
   endtask

   task automatic fill_bank();
      for (int w = 0; w < 16; w++) begin
         shadow[w] = $urandom;
         reg_wr(6'(32 + w), shadow[w]);
      end
   endtask

   task automatic check_bank(string req);
      logic [31:0] v;
      for (int w = 0; w < 16; w++) begin
         reg_rd(6'(32 + w), v);
         check(v == shadow[w], req, "bank word", v, shadow[w]);
      end
   endtask

   // full transfer: program, go, wait, check
   task automatic xfer(bit rd, logic [31:0] a, int n, bit ie);
      logic [31:0] v;
      int s0;
      reg_wr(6'd2, 32'(n));
      reg_wr(6'd3, a);
      reg_wr(6'd4, {24'd0, 7'($urandom), rd});
      reg_wr(6'd1, 32'h3);
      wr_cnt = 0; rd_cnt = 0; s0 = starts;
      reg_wr(6'd0, {30'd0, ie, 1'b1});
      wait_idle();
      reg_rd(6'd1, v);
      if (n > 64) begin
         check(starts == s0, "R7", "start count on oversize", 32'(starts), 32'(s0));
         check(v[1:0] == 2'b11, "R7", "error+done status", v, 32'h3);
      end else begin
         check(starts == s0 + 1, "R3", "one start pulse", 32'(starts), 32'(s0 + 1));
         check(st_addr == a && st_cnt == 8'(n) && st_op[0] == rd, "R3", "start fields",
               st_addr, a);
         check(v[1:0] == 2'b01, "R6", "done status", v, 32'h1);
         if (rd) begin
            check(rd_cnt == n, "R5", "read byte count", 32'(rd_cnt), 32'(n));
            for (int i = 0; i < n; i++)
               shadow[i / 4][8 * (i % 4) +: 8] = model_byte(a, i);
            check_bank("R5");
         end else begin
            check(wr_cnt == n, "R4", "write byte count", 32'(wr_cnt), 32'(n));
            for (int i = 0; i < n; i++)
               check(wr_seen[i] == shadow[i / 4][8 * (i % 4) +: 8], "R4", "write byte",
                     32'(wr_seen[i]), 32'(shadow[i / 4][8 * (i % 4) +: 8]));
         end
      end
      #1 check(irq == ie, "R10", "irq after completion", 32'(irq), 32'(ie));
   endtask

   initial begin
      logic [31:0] v;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      reg_rd(6'd0, v); check(v == 0, "R1", "ctrl after reset", v, 0);
      reg_rd(6'd1, v); check(v == 0, "R1", "status after reset", v, 0);
      check(irq == 1'b0, "R1", "irq after reset", 32'(irq), 0);

      // R2 readback
      reg_wr(6'd2, 32'd5);  reg_rd(6'd2, v); check(v == 5, "R2", "count readback", v, 5);
      reg_wr(6'd3, 32'hCAFE_0123); reg_rd(6'd3, v);
      check(v == 32'hCAFE_0123, "R2", "addr readback", v, 32'hCAFE_0123);
      reg_wr(6'd4, 32'h1A5); reg_rd(6'd4, v); check(v == 32'hA5, "R2", "opcode readback", v, 32'hA5);
      reg_wr(6'd35, 32'h1234_5678); reg_rd(6'd35, v);
      check(v == 32'h1234_5678, "R2", "data word readback", v, 32'h1234_5678);
      reg_rd(6'd9, v); check(v == 0, "R2", "unmapped reads 0", v, 0);

      // R3 / R8: busy readback and ignored writes while busy
      fill_bank();
      reg_wr(6'd2, 32'd8); reg_wr(6'd3, 32'h40); reg_wr(6'd4, 32'h10);
      wr_cnt = 0; hold = 1;
      reg_wr(6'd0, 32'h3);
      reg_rd(6'd0, v); check(v[0] == 1'b1, "R3", "go reads 1 while busy", v, 32'h3);
      reg_wr(6'd2, 32'd1); reg_wr(6'd3, 32'h99); reg_wr(6'd4, 32'h11);
      reg_wr(6'd32, 32'hDEAD_BEEF);
      reg_rd(6'd2, v); check(v == 8, "R8", "count held while busy", v, 8);
      reg_rd(6'd3, v); check(v == 32'h40, "R8", "addr held while busy", v, 32'h40);
      reg_rd(6'd4, v); check(v == 32'h10, "R8", "opcode held while busy", v, 32'h10);
      reg_rd(6'd32, v); check(v == shadow[0], "R8", "data held while busy", v, shadow[0]);
      hold = 0;
      wait_idle();
      check(wr_cnt == 8, "R4", "bytes after hold", 32'(wr_cnt), 8);
      for (int i = 0; i < 8; i++)
         check(wr_seen[i] == shadow[i / 4][8 * (i % 4) +: 8], "R4", "held write byte",
               32'(wr_seen[i]), 32'(shadow[i / 4][8 * (i % 4) +: 8]));
      reg_rd(6'd1, v); check(v[0] == 1'b1, "R6", "done after held xfer", v, 1);
      #1 check(irq == 1'b1, "R10", "irq with enable", 32'(irq), 1);

      // R9 write-1-to-clear
      reg_wr(6'd1, 32'h0); reg_rd(6'd1, v); check(v[0] == 1'b1, "R9", "write 0 keeps done", v, 1);
      reg_wr(6'd1, 32'h1); reg_rd(6'd1, v); check(v[0] == 1'b0, "R9", "write 1 clears done", v, 0);
      #1 check(irq == 1'b0, "R10", "irq drops with done", 32'(irq), 0);

      // boundaries
      xfer(1'b0, 32'h10, 0, 1'b0);   // R6 zero count
      check(wr_cnt == 0, "R6", "no bytes at count 0", 32'(wr_cnt), 0);
      xfer(1'b0, 32'h20, 65, 1'b1);  // R7 oversize
      reg_rd(6'd0, v); check(v[0] == 1'b0, "R7", "go clear after refusal", v, 0);
      fill_bank();
      xfer(1'b0, 32'h30, 64, 1'b1);  // R4 full bank write
      xfer(1'b1, 32'h3C7, 64, 1'b1); // R5 full bank read
      xfer(1'b1, 32'h551, 5, 1'b0);  // R5 partial, rest preserved

      // random mix
      for (int k = 0; k < 24; k++) begin
         int n;
         n = ($urandom % 8 == 0) ? 65 + int'($urandom % 30) : int'($urandom % 65);
         if ($urandom % 2 == 0) fill_bank();
         xfer(1'($urandom), $urandom, n, 1'($urandom));
      end

      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule